// File: doc/BRIEF.md
# LCD Common/Segment Scan Sequencer

This block drives a multiplexed passive LCD panel of up to four rows (commons) and thirty-two columns (segments). It holds a small display memory of one 4-bit word per segment and scans the panel one common at a time. On every output it gives a 2-bit code for the voltage level that the analog drivers outside the block should apply. The host writes pixels into the memory and can read any word back. The drive rate comes from a tick that is divided down from the system clock.

The panel geometry is chosen at run time. A 2-bit field sets the number of commons in the scan (two, three or four), and one bit picks 1/2 or 1/3 bias. Each full pass over the active commons is one frame. The drive polarity flips at every frame boundary, so over two frames no pixel sees a net DC voltage. Two enables control the outputs. A display enable blanks them and lets the scan keep running. A system enable also stops the divider and the scan and sends them back to their start.

Top module: `lcd_scan_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, every common and segment code is 0, rd_data is 0, and all memory words read 0. The scan starts at common 0 with positive polarity.
- R2: A write with wr_en high stores wr_data at wr_addr. rd_data gives the word at rd_addr one clock later. When a read and a write hit the same word in the same cycle, the read returns the old contents. Word n drives segment n, and bit k of that word is the pixel at common k, where 1 means on.
- R3: While sys_en is high, a scan tick occurs once every TICK_DIV clocks, with the first tick on the TICK_DIV-th enabled cycle. The active common and the polarity change only on a tick.
- R4: com_cfg sets the number of active commons N: 00 gives 2, 01 gives 3, and 10 or 11 give 4. On a tick, if the active common index plus one is at least N, the index returns to 0 and the polarity flips. Otherwise the index goes up by one.
- R5: Level codes are 0 = VSS, 1 = lower third, 2 = upper third and 3 = VLCD. Under 1/3 bias with positive polarity, the selected common is 3, other commons are 1, an on segment is 0 and an off segment is 2. With negative polarity the values are 0, 2, 3 and 1.
- R6: Under 1/2 bias, code 1 is the single mid level and code 2 never appears. With positive polarity, the selected common is 3, other commons are 1, an on segment is 0 and an off segment is 3. With negative polarity the values are 0, 1, 3 and 0.
- R7: A common whose index is N or more always shows the non-select level of the current bias and polarity.
- R8: When lcd_on is low, every output code is 0. The scan position and polarity keep advancing, so the outputs resume mid-frame when lcd_on returns.
- R9: When sys_en is low, every output code is 0, the tick divider is cleared, and the scan returns to common 0 with positive polarity.
- R10: Every output is registered. The codes seen after a clock edge reflect the scan state, the memory contents and the configuration inputs as they were just before that edge.
- R11: Common k occupies com_lvl[2k+1:2k] and segment n occupies seg_lvl[2n+1:2n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sys_en | input | 1 | System enable; low stops and clears the divider and the scan |
| lcd_on | input | 1 | Display enable; low blanks all outputs |
| com_cfg | input | 2 | Number of active commons: 00=2, 01=3, 1x=4 |
| bias_third | input | 1 | 0 selects 1/2 bias, 1 selects 1/3 bias |
| wr_en | input | 1 | Display memory write strobe |
| wr_addr | input | 5 | Word (segment) index to write |
| wr_data | input | 4 | Pixel nibble to write; bit k is common k |
| rd_addr | input | 5 | Word index to read |
| rd_data | output | 4 | Word at rd_addr, one clock later |
| com_lvl | output | 8 | Level codes of the commons, 2 bits each |
| seg_lvl | output | 64 | Level codes of the segments, 2 bits each |

## Verification
The assertions rely on a few conditions. Reset must be held for at least one clock before any of them are checked. TICK_DIV must be at least 2, so that two ticks never fall on back-to-back cycles. The configuration inputs may change at any clock edge, and the wrap rule in R4 then picks up the new count at the next tick. The stimulus changes inputs only on falling clock edges and holds reset for several cycles. It covers every commons setting with both biases and both enables, including mid-frame changes and writes during the scan.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_VSS  = 2'd0;
  localparam lvl_t LVL_LO   = 2'd1;
  localparam lvl_t LVL_HI   = 2'd2;
  localparam lvl_t LVL_VLCD = 2'd3;

  // number of commons in the scan for a configuration code
  function automatic logic [2:0] active_coms(input logic [1:0] cfg);
    logic [2:0] n;
    unique case (cfg)
      2'b00:   n = 3'd2;
      2'b01:   n = 3'd3;
      default: n = 3'd4;
    endcase
    return n;
  endfunction

  // common drive level; pol=0 is the positive frame
  function automatic lvl_t com_code(input logic sel, input logic pol, input logic third);
    lvl_t c;
    if (sel)        c = pol ? LVL_VSS : LVL_VLCD;
    else if (third) c = pol ? LVL_HI  : LVL_LO;
    else            c = LVL_LO;
    return c;
  endfunction

  // segment drive level
  function automatic lvl_t seg_code(input logic on, input logic pol, input logic third);
    lvl_t c;
    if (on)         c = pol ? LVL_VLCD : LVL_VSS;
    else if (third) c = pol ? LVL_LO   : LVL_HI;
    else            c = pol ? LVL_VSS  : LVL_VLCD;
    return c;
  endfunction

endpackage

// File: rtl/lcd_tick_gen.sv
module lcd_tick_gen #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R3

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl #(
  parameter int NUM_COM = 4,
  localparam int IDX_W = (NUM_COM > 2) ? $clog2(NUM_COM) : 1,
  localparam int CNT_W = $clog2(NUM_COM + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] ncom,
  output logic [IDX_W-1:0] idx,
  output logic             pol
);
  logic last_row;

  assign last_row = (CNT_W'(idx) + CNT_W'(1)) >= ncom;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      idx <= '0;
      pol <= 1'b0;
    end else if (tick) begin
      if (last_row) begin
        idx <= '0;
        pol <= ~pol;
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (run && tick) |=> ((idx == $past(idx) + IDX_W'(1)) || (idx == '0))); // R4
  AST_WRAP_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (run && tick) |=> ((idx == '0) == (pol != $past(pol)))); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> ($stable(idx) && $stable(pol))); // R3
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !run |=> (idx == '0 && !pol)); // R9

endmodule

// File: rtl/lcd_disp_mem.sv
module lcd_disp_mem #(
  parameter int NUM_SEG = 32,
  parameter int DATA_W  = 4,
  localparam int ADDR_W = $clog2(NUM_SEG)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_SEG*DATA_W-1:0] words
);
  logic [DATA_W-1:0] mem_q [NUM_SEG];

  // every word feeds the scan in parallel, so the store is a register array
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SEG; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mem_q[rd_addr];
  end

  for (genvar n = 0; n < NUM_SEG; n++) begin : g_flat
    assign words[n*DATA_W +: DATA_W] = mem_q[n];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data))); // R2

endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 32,
  localparam int IDX_W = (NUM_COM > 2) ? $clog2(NUM_COM) : 1,
  localparam int CNT_W = $clog2(NUM_COM + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       enable,
  input  logic                       third,
  input  logic [CNT_W-1:0]           ncom,
  input  logic [IDX_W-1:0]           idx,
  input  logic                       pol,
  input  logic [NUM_SEG*NUM_COM-1:0] words,
  output logic [2*NUM_COM-1:0]       com_lvl,
  output logic [2*NUM_SEG-1:0]       seg_lvl
);
  for (genvar k = 0; k < NUM_COM; k++) begin : g_com
    logic sel;
    assign sel = (ncom > CNT_W'(k)) && (idx == IDX_W'(k));
    always_ff @(posedge clk) begin
      if (rst || !enable) com_lvl[2*k +: 2] <= LVL_VSS;
      else                com_lvl[2*k +: 2] <= com_code(sel, pol, third);
    end
  end

  for (genvar n = 0; n < NUM_SEG; n++) begin : g_seg
    logic [NUM_COM-1:0] word_n;
    assign word_n = words[n*NUM_COM +: NUM_COM];
    always_ff @(posedge clk) begin
      if (rst || !enable) seg_lvl[2*n +: 2] <= LVL_VSS;
      else                seg_lvl[2*n +: 2] <= seg_code(word_n[idx], pol, third);
    end
  end

  function automatic int count_code(input logic [2*NUM_SEG-1:0] v, input int width, input lvl_t c);
    int cnt = 0;
    for (int i = 0; i < width; i++) if (v[2*i +: 2] == c) cnt++;
    return cnt;
  endfunction

  AST_OFF_BLANK: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (com_lvl == '0 && seg_lvl == '0)); // R8
  AST_HALF_NO_UPPER: assert property (@(posedge clk) disable iff (rst)
    (enable && !third) |=> (count_code({{(2*NUM_SEG-2*NUM_COM){1'b0}}, com_lvl}, NUM_COM, LVL_HI) == 0
                            && count_code(seg_lvl, NUM_SEG, LVL_HI) == 0)); // R6
  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (rst)
    enable |=> (count_code({{(2*NUM_SEG-2*NUM_COM){1'b0}}, com_lvl}, NUM_COM, LVL_VSS)
              + count_code({{(2*NUM_SEG-2*NUM_COM){1'b0}}, com_lvl}, NUM_COM, LVL_VLCD) <= 1)); // R5

endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COM  = 4,
  parameter int NUM_SEG  = 32,
  parameter int TICK_DIV = 128,
  localparam int ADDR_W = $clog2(NUM_SEG),
  localparam int DATA_W = NUM_COM
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sys_en,
  input  logic                 lcd_on,
  input  logic [1:0]           com_cfg,
  input  logic                 bias_third,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic [2*NUM_COM-1:0] com_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl
);
  localparam int IDX_W = (NUM_COM > 2) ? $clog2(NUM_COM) : 1;
  localparam int CNT_W = $clog2(NUM_COM + 1);

  logic                      tick;
  logic [IDX_W-1:0]          idx;
  logic                      pol;
  logic [CNT_W-1:0]          ncom;
  logic [NUM_SEG*DATA_W-1:0] words;
  logic [2:0]                ncom_raw;

  assign ncom_raw = active_coms(com_cfg);
  assign ncom     = (int'(ncom_raw) > NUM_COM) ? CNT_W'(NUM_COM) : CNT_W'(ncom_raw);

  lcd_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk (clk), .rst (rst), .run (sys_en), .tick (tick)
  );

  lcd_scan_ctrl #(.NUM_COM(NUM_COM)) u_scan (
    .clk (clk), .rst (rst), .run (sys_en), .tick (tick),
    .ncom (ncom), .idx (idx), .pol (pol)
  );

  lcd_disp_mem #(.NUM_SEG(NUM_SEG), .DATA_W(DATA_W)) u_mem (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data), .words (words)
  );

  lcd_level_enc #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_enc (
    .clk (clk), .rst (rst), .enable (sys_en && lcd_on), .third (bias_third),
    .ncom (ncom), .idx (idx), .pol (pol), .words (words),
    .com_lvl (com_lvl), .seg_lvl (seg_lvl)
  );

  AST_SYS_OFF_BLANK: assert property (@(posedge clk) disable iff (rst)
    !sys_en |=> (com_lvl == '0 && seg_lvl == '0)); // R9

endmodule

// File: tb/lcd_scan_seq_tb.sv
module lcd_scan_seq_tb;
  localparam int NS  = 32;
  localparam int NC  = 4;
  localparam int DIV = 128;

  logic clk = 1'b0, rst = 1'b1, sys_en = 1'b0, lcd_on = 1'b0, bias_third = 1'b0, wr_en = 1'b0;
  logic [1:0] com_cfg = 2'b10;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [3:0] wr_data = '0;
  logic [3:0] rd_data;
  logic [2*NC-1:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;

  always #5 clk = ~clk;

  lcd_scan_seq u_dut (
    .clk (clk), .rst (rst), .sys_en (sys_en), .lcd_on (lcd_on), .com_cfg (com_cfg),
    .bias_third (bias_third), .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_addr (rd_addr), .rd_data (rd_data), .com_lvl (com_lvl), .seg_lvl (seg_lvl)
  );

  int checks = 0, errors = 0;
  string tag = "R1";
  bit cmp_on = 0, done = 0;

  // reference model state
  int m_cnt = 0, m_idx = 0, m_pol = 0;
  logic [3:0] m_mem [NS];
  logic [2*NC-1:0] e_com;
  logic [2*NS-1:0] e_seg;
  logic [3:0] e_rd;

  function automatic logic [1:0] ref_com(int sel, int pol, int third);
    if (sel != 0) return (pol != 0) ? 2'd0 : 2'd3;
    if (third != 0) return (pol != 0) ? 2'd2 : 2'd1;
    return 2'd1;
  endfunction

  function automatic logic [1:0] ref_seg(int on, int pol, int third);
    if (on != 0) return (pol != 0) ? 2'd3 : 2'd0;
    if (third != 0) return (pol != 0) ? 2'd1 : 2'd2;
    return (pol != 0) ? 2'd0 : 2'd3;
  endfunction

  always @(posedge clk) begin
    int n;
    n = (com_cfg == 2'b00) ? 2 : (com_cfg == 2'b01) ? 3 : 4;
    if (rst) begin
      e_com = '0; e_seg = '0; e_rd = '0;
      m_cnt = 0; m_idx = 0; m_pol = 0;
      for (int i = 0; i < NS; i++) m_mem[i] = '0;
    end else begin
      e_rd = m_mem[rd_addr];
      if (!(sys_en && lcd_on)) begin
        e_com = '0; e_seg = '0;
      end else begin
        for (int k = 0; k < NC; k++)
          e_com[2*k +: 2] = ref_com(int'(k < n && k == m_idx), m_pol, int'(bias_third));
        for (int s = 0; s < NS; s++)
          e_seg[2*s +: 2] = ref_seg(int'(m_mem[s][m_idx]), m_pol, int'(bias_third));
      end
      if (wr_en) m_mem[wr_addr] = wr_data;
      if (!sys_en) begin
        m_cnt = 0; m_idx = 0; m_pol = 0;
      end else if (m_cnt == DIV - 1) begin
        m_cnt = 0;
        if (m_idx + 1 >= n) begin m_idx = 0; m_pol = 1 - m_pol; end
        else m_idx = m_idx + 1;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
    cmp_on = 1;
  end

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("com_lvl", 64'(com_lvl), 64'(e_com));
      check("seg_lvl", seg_lvl, e_seg);
      check("rd_data", 64'(rd_data), 64'(e_rd));
    end
  end

  task automatic wait_cycles(int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic write_word(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 4'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    // R1: reset state on every output
    tag = "R1";
    wait_cycles(4);
    @(negedge clk) rst = 1'b0;
    wait_cycles(3);

    // R2 R11: fill memory, read every word back, read-during-write returns old data
    tag = "R2 R11";
    for (int i = 0; i < NS; i++) write_word(i, (i * 7 + 3) & 15);
    for (int i = 0; i < NS; i++) begin
      @(negedge clk) rd_addr = 5'(i);
    end
    @(negedge clk);
    rd_addr = 5'd9; wr_en = 1'b1; wr_addr = 5'd9; wr_data = 4'hA;
    @(negedge clk) wr_en = 1'b0;
    wait_cycles(2);

    // R3 R5 R10: four commons, 1/3 bias, several frames of both polarities
    tag = "R3 R5 R10";
    com_cfg = 2'b10; bias_third = 1'b1; sys_en = 1'b1; lcd_on = 1'b1;
    wait_cycles(2100);

    // R4 R7: three commons, 1/3 bias, changed mid-frame
    tag = "R4 R7";
    com_cfg = 2'b01;
    wait_cycles(1600);

    // R6 R7: two commons, 1/2 bias
    tag = "R6 R7";
    com_cfg = 2'b00; bias_third = 1'b0;
    wait_cycles(1600);

    // R4: code 11 behaves as four commons
    tag = "R4";
    com_cfg = 2'b11;
    wait_cycles(1100);

    // R8: display off blanks, scan keeps running
    tag = "R8";
    bias_third = 1'b1; com_cfg = 2'b10;
    wait_cycles(200);
    lcd_on = 1'b0;
    wait_cycles(300);
    lcd_on = 1'b1;
    wait_cycles(600);

    // R9: system disable clears divider and scan
    tag = "R9";
    wait_cycles(77);
    sys_en = 1'b0;
    wait_cycles(200);
    sys_en = 1'b1;
    wait_cycles(700);

    // R2 R10: writes while scanning show up on the next output update
    tag = "R2 R10";
    for (int i = 0; i < 8; i++) begin
      write_word(i * 4, 15 - i);
      wait_cycles(60);
    end
    wait_cycles(600);

    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule